// File: doc/BRIEF.md
# Dual-Mode Population Count Unit

This unit reports how many bits are set in an operand whose width is a parameter. A second parameter picks one of two implementations behind identical ports. In the single-cycle variant, an adder network counts every bit of the operand. The sum is registered on each clock edge, so the count output always reflects the operand present one clock earlier.

In the iterative variant, a start request arrives while the unit is idle. The unit captures the operand and then inspects one bit per clock edge. When the last bit has been added, it publishes the total and signals that it is idle again. Both variants expose the start and ready handshake, so the surrounding logic can swap one variant for the other without rewiring. In the single-cycle variant these two ports carry no information: ready stays high and start has no effect.

Top module: `popCountUnit`

## Requirements
- R1: The count output is $clog2(WIDTH+1) bits wide. An operand with all WIDTH bits set yields exactly WIDTH.
- R2: While the synchronous reset is sampled high, the unit clears count to zero. After such a reset edge, ready is 1 and the unit is idle.
- R3: With MULTI_CYCLE=0, after every clock edge that is not a reset, count equals the number of set bits in value as sampled at that edge.
- R4: With MULTI_CYCLE=0, ready is 1 after every edge, and start has no effect on count or ready.
- R5: With MULTI_CYCLE=1, an edge that samples start=1 while ready=1 accepts an operation. From the next cycle, ready is 0 for exactly WIDTH cycles, and then it returns to 1.
- R6: With MULTI_CYCLE=1, count takes the number of set bits of the accepted operand at the same edge where ready returns to 1, which is WIDTH edges after acceptance.
- R7: With MULTI_CYCLE=1, start sampled while ready=0 is ignored. The operation in flight neither restarts nor changes its completion edge.
- R8: With MULTI_CYCLE=1, changes on value after the accepting edge have no effect on the result.
- R9: With MULTI_CYCLE=1, count keeps its previous result while an operation is in flight and while the unit is idle. It changes only at a completion edge or at reset.
- R10: The iterative variant behaves as R5 to R9 state for a small operand width (WIDTH=3).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a count (iterative variant only) |
| value | input | WIDTH | Operand |
| count | output | $clog2(WIDTH+1) | Registered number of set bits |
| ready | output | 1 | Unit idle and count valid |

## Verification
The embedded properties take two things for granted. Reset is held across at least one rising edge. The start and value inputs change only between edges. Beyond that, start may be asserted at any time, including during a count. The stimulus keeps to these assumptions by driving inputs on the falling edge only. It deliberately raises start and scrambles value while the iterative variant is busy, which exercises the ignore and latch behaviour. It also sends back-to-back requests with random operands and random idle gaps.

// File: rtl/popcnt_pkg.sv
package popcnt_pkg;

  typedef enum logic {
    CTRL_IDLE = 1'b0,
    CTRL_BUSY = 1'b1
  } ctrlState_e;

  // strobes issued by the control to the datapath
  typedef struct packed {
    logic load;    // capture operand / single-cycle capture
    logic step;    // consume one operand bit
    logic finish;  // last bit: publish result
  } ctrlStrobes_t;

endpackage

// File: rtl/popCtrl.sv
module popCtrl
  import popcnt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit MULTI_CYCLE = 1'b1,
  parameter int CNT_W       = $clog2(WIDTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  output logic         ready,
  output ctrlStrobes_t strobes
);

  generate
    if (MULTI_CYCLE) begin : g_iter
      ctrlState_e      state;
      logic [CNT_W-1:0] remaining;

      always_ff @(posedge clk) begin
        if (rst) begin
          state     <= CTRL_IDLE;
          remaining <= '0;
        end else begin
          case (state)
            CTRL_IDLE: begin
              if (start) begin
                state     <= CTRL_BUSY;
                remaining <= CNT_W'(WIDTH);
              end
            end
            CTRL_BUSY: begin
              remaining <= remaining - 1'b1;
              if (remaining == CNT_W'(1)) begin
                state <= CTRL_IDLE;
              end
            end
            default: state <= CTRL_IDLE;
          endcase
        end
      end

      always_comb begin
        ready          = (state == CTRL_IDLE);
        strobes.load   = (state == CTRL_IDLE) && start;
        strobes.step   = (state == CTRL_BUSY);
        strobes.finish = (state == CTRL_BUSY) && (remaining == CNT_W'(1));
      end

      AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        (ready && start) |=> !ready); // R5

      AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (rst)
        (!ready && start && remaining != CNT_W'(1)) |=> (!ready && remaining == $past(remaining) - 1'b1)); // R7

      AST_REMAIN_RANGE: assert property (@(posedge clk) disable iff (rst)
        remaining <= CNT_W'(WIDTH)); // R5

    end else begin : g_single
      logic readyQ;

      always_ff @(posedge clk) begin
        if (rst) readyQ <= 1'b1;
        else     readyQ <= 1'b1;
      end

      always_comb begin
        ready          = readyQ;
        strobes.load   = 1'b1;
        strobes.step   = 1'b0;
        strobes.finish = 1'b0;
      end

      AST_SINGLE_START_INERT: assert property (@(posedge clk) disable iff (rst)
        start |=> ready); // R4
    end
  endgenerate

endmodule

// File: rtl/popDatapath.sv
module popDatapath
  import popcnt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit MULTI_CYCLE = 1'b1,
  parameter int CNT_W       = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] value,
  input  ctrlStrobes_t     strobes,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] countQ;
  assign count = countQ;

  generate
    if (MULTI_CYCLE) begin : g_iter
      logic [WIDTH-1:0] operandSh;
      logic [CNT_W-1:0] acc;
      logic [CNT_W-1:0] accNext;

      assign accNext = acc + CNT_W'(operandSh[0]);

      always_ff @(posedge clk) begin
        if (rst) begin
          operandSh <= '0;
          acc       <= '0;
          countQ    <= '0;
        end else begin
          if (strobes.load) begin
            operandSh <= value;
            acc       <= '0;
          end else if (strobes.step) begin
            operandSh <= operandSh >> 1;
            acc       <= accNext;
          end
          if (strobes.finish) begin
            countQ <= accNext;
          end
        end
      end

      AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !strobes.finish |=> $stable(countQ)); // R9

      AST_ACC_BOUND: assert property (@(posedge clk) disable iff (rst)
        acc <= CNT_W'(WIDTH)); // R1

    end else begin : g_single
      logic [CNT_W-1:0] bitSum;

      always_comb begin
        bitSum = '0;
        for (int i = 0; i < WIDTH; i++) begin
          bitSum = bitSum + CNT_W'(value[i]);
        end
      end

      always_ff @(posedge clk) begin
        if (rst) begin
          countQ <= '0;
        end else if (strobes.load && !strobes.step && !strobes.finish) begin
          countQ <= bitSum;
        end
      end

      AST_SINGLE_TRACK: assert property (@(posedge clk) disable iff (rst)
        !rst |=> countQ == CNT_W'($countones($past(value)))); // R3
    end
  endgenerate

endmodule

// File: rtl/popCountUnit.sv
module popCountUnit
  import popcnt_pkg::*;
#(
  parameter int WIDTH       = 16,
  parameter bit MULTI_CYCLE = 1'b1,
  localparam int CNT_W      = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WIDTH-1:0] value,
  output logic [CNT_W-1:0] count,
  output logic             ready
);

  ctrlStrobes_t strobes;

  popCtrl #(
    .WIDTH       (WIDTH),
    .MULTI_CYCLE (MULTI_CYCLE),
    .CNT_W       (CNT_W)
  ) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .ready   (ready),
    .strobes (strobes)
  );

  popDatapath #(
    .WIDTH       (WIDTH),
    .MULTI_CYCLE (MULTI_CYCLE),
    .CNT_W       (CNT_W)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .value   (value),
    .strobes (strobes),
    .count   (count)
  );

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (count == '0 && ready)); // R2

endmodule

// File: tb/popCountUnit_tb.sv
module popCountUnit_tb;

  localparam int W  = 16;
  localparam int NW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] value = '0;

  logic [$clog2(W+1)-1:0]  countM, countS;
  logic [$clog2(NW+1)-1:0] countN;
  logic readyM, readyS, readyN;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  bit checking = 1'b0;
  string curTag = "R2";

  always #4 clk = ~clk;

  popCountUnit #(.WIDTH(W), .MULTI_CYCLE(1'b1)) u_dut (
    .clk(clk), .rst(rst), .start(start), .value(value), .count(countM), .ready(readyM));

  popCountUnit #(.WIDTH(W), .MULTI_CYCLE(1'b0)) u_dutSingle (
    .clk(clk), .rst(rst), .start(start), .value(value), .count(countS), .ready(readyS));

  popCountUnit #(.WIDTH(NW), .MULTI_CYCLE(1'b1)) u_dutNarrow (
    .clk(clk), .rst(rst), .start(start), .value(value[NW-1:0]), .count(countN), .ready(readyN));

  // behavioural reference models
  bit mBusy = 0; int mLeft = 0; logic [W-1:0] mOp = '0; int mCnt = 0;
  bit nBusy = 0; int nLeft = 0; logic [NW-1:0] nOp = '0; int nCnt = 0;
  int sCnt = 0;

  always @(posedge clk) begin
    if (rst) begin
      mBusy = 0; mCnt = 0; nBusy = 0; nCnt = 0; sCnt = 0;
    end else begin
      sCnt = $countones(value);
      if (mBusy) begin
        mLeft--;
        if (mLeft == 0) begin mBusy = 0; mCnt = $countones(mOp); end
      end else if (start) begin
        mBusy = 1; mLeft = W; mOp = value;
      end
      if (nBusy) begin
        nLeft--;
        if (nLeft == 0) begin nBusy = 0; nCnt = $countones(nOp); end
      end else if (start) begin
        nBusy = 1; nLeft = NW; nOp = value[NW-1:0];
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (checking && !done) begin
      chk({curTag, " iterative count"}, int'(countM), mCnt);
      chk({curTag, " R5 iterative ready"}, int'(readyM), int'(!mBusy));
      chk("R3 single count", int'(countS), sCnt);
      chk("R4 single ready", int'(readyS), 1);
      chk("R10 narrow count", int'(countN), nCnt);
      chk("R10 narrow ready", int'(readyN), int'(!nBusy));
    end
  end

  task automatic runOp(logic [W-1:0] v, bit holdStart, bit scramble);
    @(negedge clk);
    start = 1'b1; value = v;
    for (int k = 0; k < W + 1; k++) begin
      @(negedge clk);
      if (!holdStart) start = 1'b0;
      if (scramble) value = W'($urandom);
    end
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checking = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R2: reset state
    chk("R2 reset count", int'(countM), 0);
    chk("R2 reset ready", int'(readyM), 1);
    chk("R2 reset narrow", int'(countN) + int'(!readyN), 0);

    curTag = "R6";
    runOp(16'hA5C3, 1'b0, 1'b0);
    runOp(16'h0001, 1'b0, 1'b0);
    runOp(16'h0000, 1'b0, 1'b0);

    curTag = "R1";
    runOp(16'hFFFF, 1'b0, 1'b0);
    chk("R1 all ones wide", int'(countM), W);
    chk("R1 all ones narrow", int'(countN), NW);
    chk("R1 count width", $bits(countM), 5);

    curTag = "R7";
    runOp(16'h8421, 1'b1, 1'b0);

    curTag = "R8";
    runOp(16'h7E00, 1'b0, 1'b1);
    chk("R8 latched operand", int'(countM), 6);

    curTag = "R9";
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      value = W'($urandom);
    end
    chk("R9 idle hold", int'(countM), 6);

    curTag = "R6";
    for (int n = 0; n < 25; n++) begin
      runOp(W'($urandom), 1'b0, n[0]);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end

    curTag = "R2";
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R2 mid reset count", int'(countM), 0);
    chk("R2 mid reset ready", int'(readyM), 1);

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule